// File: doc/BRIEF.md
# SPI Master with Selectable Attribute Sets

This block is a master-mode serial peripheral interface transfer engine. It holds eight clock-and-transfer attribute sets. Each set is written through a simple configuration port. Each set fixes the bit-clock division, an optional double-rate division mode, the frame length, the idle level of SCK, the clock phase and the bit order. The rarely used continuous-clock and modified-timing options are stored in a set only so that an illegal combination can be rejected.

The host starts a frame with a single-cycle `start`, a data word and the index of the attribute set to use. The engine copies the chosen set when the frame starts, so a later configuration write does not disturb the frame in flight. It asserts chip select, toggles SCK and shifts data out on MOSI while it samples MISO. When the frame ends it releases chip select, presents the received word and raises `done` for one cycle. Between frames SCK rests at the polarity of the set used most recently.

Top module: `spi_attr_master`

## Requirements
- R1: `cfg_we` stores `cfg_wdata` into the set named by `cfg_idx`. There are eight sets. After reset every set holds a frame field of all ones and zeros in every other field. This gives 16-bit frames, a division ratio of 4, SCK idle low, phase 0 and MSB first. After reset `cs_n`=1, `sck`=0, `busy`=0, `done`=0 and `attr_err`=0.
- R2: The attribute word layout is as follows. [3:0] frame field F, [4] idle polarity, [5] clock phase, [6] LSB-first, [7] double-rate, [11:8] divider D, [12] continuous-clock option, [13] modified-timing option.
- R3: A frame carries F+1 bits when F>=3 and 4 bits when F<3. SCK makes exactly that many leading edges per frame.
- R4: With double-rate clear, one SCK period is 2*(D+2) system cycles, split evenly between the active and idle levels.
- R5: With double-rate set, the period is R=D+2 cycles. The active-level part lasts ceil(R/2) cycles with phase 0 and floor(R/2) cycles with phase 1, and the idle-level part lasts the remainder. Chip select leads the first edge and trails the last edge by one idle-level part each.
- R6: While chip select is inactive, SCK stays at the polarity bit of the set in use (0 low, 1 high), and it is already at that level when chip select falls.
- R7: With phase 0, MISO is captured on the leading edge and MOSI changes on the trailing edge, with the first bit on MOSI when chip select falls. With phase 1, MOSI changes on the leading edge and MISO is captured on the trailing edge.
- R8: With LSB-first clear, bit F' = N-1 of `tx_data` goes out first and the first received bit lands in bit N-1 of `rx_data`. With it set, bit 0 goes first. Bits of `rx_data` at N and above read 0.
- R9: `done` is high for exactly one cycle, in the cycle where `cs_n` returns high, and `rx_data` holds the received word from then on.
- R10: A start naming a set whose ratio R is 2 or 3 with either the continuous-clock or modified-timing bit set is rejected. `attr_err` pulses for one cycle, chip select stays high and no `done` follows.
- R11: A `start` while `busy` is high is ignored and does not change the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Attribute set write strobe |
| cfg_idx | input | 3 | Attribute set written |
| cfg_wdata | input | 14 | Attribute word (layout in R2) |
| start | input | 1 | Begin a frame |
| start_idx | input | 3 | Attribute set for the frame |
| tx_data | input | 16 | Word to transmit |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | Single-cycle end-of-frame pulse |
| rx_data | output | 16 | Received word |
| attr_err | output | 1 | Start rejected for an illegal set |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The assertions check on every cycle that SCK stays still while chip select is idle, that `done` is a lone pulse coinciding with chip-select release, and that every release of chip select comes with `done`. They also check that a rejected start never asserts chip select. Only the bench scenarios can show the things that depend on the chosen set. These are the per-phase cycle counts for even and odd ratios, the edge count per frame, the bit order in both directions, the capture edge for each phase setting, and the frame length clamp. The bench shows them by running a serial slave model and a scoreboard against several distinct sets.

// File: rtl/spi_attr_pkg.sv
package spi_attr_pkg;
  localparam int FSZ_W  = 4;
  localparam int BRD_W  = 4;
  localparam int DATA_W = 2 ** FSZ_W;
  localparam int BIT_W  = $clog2(DATA_W) + 1;
  localparam int HALF_W = $clog2((2 ** BRD_W) + 2);
  localparam int RAT_W  = HALF_W + 1;

  typedef struct packed {
    logic             modt;
    logic             cont;
    logic [BRD_W-1:0] brd;
    logic             dbl;
    logic             lsb;
    logic             cpha;
    logic             cpol;
    logic [FSZ_W-1:0] fsz;
  } attr_t;

  localparam int ATTR_W = $bits(attr_t);

  localparam attr_t ATTR_RST = '{modt: 1'b0, cont: 1'b0, brd: '0, dbl: 1'b0,
                                 lsb: 1'b0, cpha: 1'b0, cpol: 1'b0, fsz: '1};

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_ACT, ST_TAIL} xfer_st_t;
endpackage

// File: rtl/spi_attr_bank.sv
module spi_attr_bank
  import spi_attr_pkg::*;
#(
  parameter  int NSETS = 8,
  localparam int IDX_W = $clog2(NSETS)
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  attr_t            wr_attr,
  input  logic [IDX_W-1:0] rd_idx,
  output attr_t            rd_attr
);
  attr_t sets_q [NSETS];

  for (genvar g = 0; g < NSETS; g++) begin : g_set
    logic  hit;
    attr_t set_d;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    always_comb begin
      set_d = sets_q[g];
      if (hit) set_d = wr_attr;
    end
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) sets_q[g] <= ATTR_RST;
      else         sets_q[g] <= set_d;
    end
  end

  assign rd_attr = sets_q[rd_idx];
endmodule

// File: rtl/spi_attr_decode.sv
module spi_attr_decode
  import spi_attr_pkg::*;
(
  input  attr_t             attr,
  output logic [BIT_W-1:0]  n_bits,
  output logic [HALF_W-1:0] len_act,
  output logic [HALF_W-1:0] len_idle,
  output logic              legal
);
  logic [RAT_W-1:0] base;
  logic [RAT_W-1:0] ratio;
  logic [RAT_W-1:0] act_w;

  always_comb begin
    base     = RAT_W'(attr.brd) + RAT_W'(2);
    ratio    = attr.dbl ? base : RAT_W'(base << 1);
    act_w    = attr.cpha ? (ratio >> 1) : ((ratio + RAT_W'(1)) >> 1);
    len_act  = HALF_W'(act_w);
    len_idle = HALF_W'(ratio - act_w);
    n_bits   = (attr.fsz < FSZ_W'(3)) ? BIT_W'(4) : BIT_W'(attr.fsz) + BIT_W'(1);
    legal    = !(((ratio == RAT_W'(2)) || (ratio == RAT_W'(3))) && (attr.cont || attr.modt));
  end
endmodule

// File: rtl/spi_attr_master.sv
module spi_attr_master
  import spi_attr_pkg::*;
#(
  parameter  int NSETS = 8,
  localparam int IDX_W = $clog2(NSETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ATTR_W-1:0] cfg_wdata,
  input  logic              start,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic [DATA_W-1:0] tx_data,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_data,
  output logic              attr_err,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);
  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  attr_t             sel;
  logic [BIT_W-1:0]  sel_bits;
  logic [HALF_W-1:0] sel_act, sel_idle;
  logic              sel_legal;

  spi_attr_bank #(.NSETS(NSETS)) u_bank (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_idx),
    .wr_attr (attr_t'(cfg_wdata)),
    .rd_idx  (start_idx),
    .rd_attr (sel)
  );

  spi_attr_decode u_dec (
    .attr     (sel),
    .n_bits   (sel_bits),
    .len_act  (sel_act),
    .len_idle (sel_idle),
    .legal    (sel_legal)
  );

  xfer_st_t          st_q, st_d;
  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic [BIT_W-1:0]  idx_q, idx_d;
  logic [BIT_W-1:0]  bits_q, bits_d;
  logic [HALF_W-1:0] lact_q, lact_d, lidle_q, lidle_d;
  logic              cpol_q, cpol_d, cpha_q, cpha_d, lsb_q, lsb_d;
  logic [DATA_W-1:0] tx_q, tx_d, rxs_q, rxs_d, rx_q, rx_d;
  logic              sck_q, sck_d, cs_n_q, cs_n_d, mosi_q, mosi_d;
  logic              done_q, done_d, err_q, err_d;

  logic [FSZ_W-1:0]  pos_now, pos_nxt, pos_first;
  logic              cnt_zero, last_bit;

  assign pos_now   = FSZ_W'(lsb_q ? idx_q : bits_q - BIT_W'(1) - idx_q);
  assign pos_nxt   = FSZ_W'(lsb_q ? idx_q + BIT_W'(1) : bits_q - BIT_W'(2) - idx_q);
  assign pos_first = FSZ_W'(sel.lsb ? BIT_W'(0) : sel_bits - BIT_W'(1));
  assign cnt_zero  = (cnt_q == '0);
  assign last_bit  = (idx_q == bits_q - BIT_W'(1));

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    bits_d  = bits_q;
    lact_d  = lact_q;
    lidle_d = lidle_q;
    cpol_d  = cpol_q;
    cpha_d  = cpha_q;
    lsb_d   = lsb_q;
    tx_d    = tx_q;
    rxs_d   = rxs_q;
    rx_d    = rx_q;
    sck_d   = sck_q;
    cs_n_d  = cs_n_q;
    mosi_d  = mosi_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (!sel_legal) begin
            err_d = 1'b1;
          end else begin
            st_d    = ST_WAIT;
            bits_d  = sel_bits;
            lact_d  = sel_act;
            lidle_d = sel_idle;
            cpol_d  = sel.cpol;
            cpha_d  = sel.cpha;
            lsb_d   = sel.lsb;
            tx_d    = tx_data;
            rxs_d   = '0;
            idx_d   = '0;
            cnt_d   = sel_idle - HALF_W'(1);
            sck_d   = sel.cpol;
            cs_n_d  = 1'b0;
            if (!sel.cpha) mosi_d = tx_data[pos_first];
          end
        end
      end
      ST_WAIT: begin
        if (cnt_zero) begin
          st_d  = ST_ACT;
          cnt_d = lact_q - HALF_W'(1);
          sck_d = ~cpol_q;
          if (!cpha_q) rxs_d[pos_now] = miso;
          else         mosi_d = tx_q[pos_now];
        end else begin
          cnt_d = cnt_q - HALF_W'(1);
        end
      end
      ST_ACT: begin
        if (cnt_zero) begin
          cnt_d = lidle_q - HALF_W'(1);
          sck_d = cpol_q;
          if (cpha_q) rxs_d[pos_now] = miso;
          if (last_bit) begin
            st_d = ST_TAIL;
          end else begin
            st_d  = ST_WAIT;
            idx_d = idx_q + BIT_W'(1);
            if (!cpha_q) mosi_d = tx_q[pos_nxt];
          end
        end else begin
          cnt_d = cnt_q - HALF_W'(1);
        end
      end
      ST_TAIL: begin
        if (cnt_zero) begin
          st_d   = ST_IDLE;
          cs_n_d = 1'b1;
          done_d = 1'b1;
          rx_d   = rxs_q;
          mosi_d = 1'b0;
        end else begin
          cnt_d = cnt_q - HALF_W'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      bits_q  <= BIT_W'(DATA_W);
      lact_q  <= HALF_W'(1);
      lidle_q <= HALF_W'(1);
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      lsb_q   <= 1'b0;
      tx_q    <= '0;
      rxs_q   <= '0;
      rx_q    <= '0;
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      mosi_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      bits_q  <= bits_d;
      lact_q  <= lact_d;
      lidle_q <= lidle_d;
      cpol_q  <= cpol_d;
      cpha_q  <= cpha_d;
      lsb_q   <= lsb_d;
      tx_q    <= tx_d;
      rxs_q   <= rxs_d;
      rx_q    <= rx_d;
      sck_q   <= sck_d;
      cs_n_q  <= cs_n_d;
      mosi_q  <= mosi_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
  assign rx_data  = rx_q;
  assign attr_err = err_q;
  assign sck      = sck_q;
  assign mosi     = mosi_q;
  assign cs_n     = cs_n_q;
endmodule

// File: rtl/spi_attr_master_chk.sv
module spi_attr_master_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic attr_err,
  input logic sck,
  input logic cs_n
);
  // R9: end-of-frame strobe never lasts two cycles
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: the strobe comes with chip select released and the engine free
  a_r9_done_cs_released: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !busy));

  // R9: chip select only returns high at the end of a frame
  a_r9_cs_rise_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> done);

  // R6: no SCK activity while chip select stays inactive
  a_r6_sck_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> $stable(sck));

  // R10: a rejected start leaves chip select inactive
  a_r10_err_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
    attr_err |-> (cs_n && !busy));
endmodule

bind spi_attr_master spi_attr_master_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .attr_err (attr_err),
  .sck      (sck),
  .cs_n     (cs_n)
);

// File: tb/test_spi_attr_master.sv
module test_spi_attr_master;
  import spi_attr_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [2:0]        cfg_idx = '0;
  logic [ATTR_W-1:0] cfg_wdata = '0;
  logic              start = 1'b0;
  logic [2:0]        start_idx = '0;
  logic [DATA_W-1:0] tx_data = '0;
  logic              busy, done, attr_err, sck, mosi, cs_n;
  logic [DATA_W-1:0] rx_data;
  logic              miso = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_attr_master i_spi_attr_master (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .start(start), .start_idx(start_idx),
    .tx_data(tx_data), .busy(busy), .done(done), .rx_data(rx_data),
    .attr_err(attr_err), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  typedef struct {
    logic [15:0] rx_exp;
    logic [15:0] tx_exp;
    int          nbits;
    int          la;
    int          lb;
    logic        cpol;
  } exp_t;

  exp_t q[$];
  int n_checks = 0, n_fail = 0, n_done = 0, n_cs_fall = 0;
  bit finished = 0;

  // slave model state, set by the driver before each start
  logic [15:0] s_word, s_mosi;
  logic        s_lsb, s_cpha, s_cpol;
  int          s_n, s_la, s_lb, sidx, run, lead_cnt;
  logic        prev_cs = 1'b1, prev_sck = 1'b0, run_bad, idle_bad;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [ATTR_W-1:0] mk(int fsz, bit cpol, bit cpha, bit lsb,
                                           bit dbl, int brd, bit cont, bit modt);
    return {modt, cont, 4'(brd), dbl, lsb, cpha, cpol, 4'(fsz)};
  endfunction

  function automatic int spos(int i);
    return s_lsb ? i : s_n - 1 - i;
  endfunction

  task automatic cfg_write(int idx, logic [ATTR_W-1:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // driver: computes expectations from the requirements and queues them
  task automatic launch(int idx, int fsz, bit cpol, bit cpha, bit lsb, bit dbl,
                        int brd, logic [15:0] tx, logic [15:0] sw);
    exp_t e;
    int r;
    logic [15:0] mask;
    while (busy) @(negedge clk);
    @(negedge clk);
    e.nbits = (fsz < 3) ? 4 : fsz + 1;
    r = dbl ? brd + 2 : 2 * (brd + 2);
    e.la = cpha ? r / 2 : (r + 1) / 2;
    e.lb = r - e.la;
    e.cpol = cpol;
    mask = 16'((32'h1 << e.nbits) - 1);
    e.rx_exp = sw & mask;
    e.tx_exp = tx & mask;
    q.push_back(e);
    s_word = sw; s_lsb = lsb; s_cpha = cpha; s_cpol = cpol;
    s_n = e.nbits; s_la = e.la; s_lb = e.lb;
    start = 1'b1; start_idx = 3'(idx); tx_data = tx;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int target;
    target = n_done + 1;
    while (n_done < target) @(negedge clk);
  endtask

  task automatic frame(int idx, int fsz, bit cpol, bit cpha, bit lsb, bit dbl,
                       int brd, logic [15:0] tx, logic [15:0] sw);
    cfg_write(idx, mk(fsz, cpol, cpha, lsb, dbl, brd, 1'b0, 1'b0));
    launch(idx, fsz, cpol, cpha, lsb, dbl, brd, tx, sw);
    wait_done();
  endtask

  // monitor: slave model, phase timing and scoreboard
  always @(negedge clk) begin
    if (!cs_n) begin
      if (prev_cs) begin
        n_cs_fall++;
        run = 1; sidx = 0; s_mosi = '0; lead_cnt = 0; run_bad = 1'b0;
        idle_bad = (sck != s_cpol);
        if (!s_cpha) miso = s_word[spos(0)];
      end else if (sck == prev_sck) begin
        run++;
      end else begin
        if (run != ((prev_sck == s_cpol) ? s_lb : s_la)) run_bad = 1'b1;
        run = 1;
        if (sck != s_cpol) lead_cnt++;
        if ((sck != s_cpol) != s_cpha) begin
          s_mosi[spos(sidx)] = mosi;
          if (s_cpha) sidx++;
        end else if (!s_cpha) begin
          sidx++;
          if (sidx < s_n) miso = s_word[spos(sidx)];
        end else begin
          miso = s_word[spos(sidx)];
        end
      end
    end else if (!prev_cs) begin
      if (run != s_lb) run_bad = 1'b1;
    end
    if (done) begin
      if (q.size() == 0) begin
        check(1'b0, "R11", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(rx_data == e.rx_exp, "R7 R8", "rx_data", rx_data, e.rx_exp);
        check(s_mosi == e.tx_exp, "R7 R8", "mosi word", s_mosi, e.tx_exp);
        check(lead_cnt == e.nbits, "R3", "leading edges", lead_cnt, e.nbits);
        check(!run_bad, "R4/R5", "phase lengths", e.la, e.lb);
        check(!idle_bad && sck == e.cpol, "R6", "idle sck level", sck, e.cpol);
        check(cs_n == 1'b1, "R9", "cs_n at done", cs_n, 1);
      end
      n_done++;
    end
    prev_cs = cs_n;
    prev_sck = sck;
  end

  initial begin
    int fall0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(cs_n && !sck && !busy && !done && !attr_err, "R1", "reset outputs",
          {cs_n, sck, busy, done, attr_err}, 5'b10000);
    // R1: unwritten set 0 = 16 bits, ratio 4, mode 0, MSB first
    launch(0, 15, 0, 0, 0, 0, 0, 16'hA5C3, 16'h3C5A);
    wait_done();
    // R2 R4: normal ratio 6, polarity high, phase 0, 8 bits
    frame(1, 7, 1, 0, 0, 0, 1, 16'h00B7, 16'h00E4);
    // R5 R8: double rate ratio 3, phase 1, LSB first, 12 bits
    frame(2, 11, 0, 1, 1, 1, 1, 16'h0ABC, 16'h0573);
    // R3 R5: frame field 1 clamps to 4 bits, ratio 5, phase 1
    frame(3, 1, 1, 1, 0, 1, 3, 16'hFFF9, 16'hFFF6);
    // R5 R8: ratio 7 phase 0 LSB first 5 bits
    frame(4, 4, 0, 0, 1, 1, 5, 16'h0013, 16'h000D);
    // R10: ratio 2 with continuous clock, ratio 3 with modified timing
    cfg_write(5, mk(7, 0, 0, 0, 1, 0, 1, 0));
    cfg_write(6, mk(7, 0, 0, 0, 1, 1, 0, 1));
    for (int k = 5; k <= 6; k++) begin
      int d0;
      d0 = n_done;
      @(negedge clk);
      start = 1'b1; start_idx = 3'(k);
      @(negedge clk);
      start = 1'b0;
      check(attr_err && cs_n, "R10", "rejected start", {attr_err, cs_n}, 2'b11);
      repeat (12) @(negedge clk);
      check(cs_n && n_done == d0 && !attr_err, "R10", "no frame after reject",
            n_done - d0, 0);
    end
    // R10: ratio 4 with continuous clock is legal
    cfg_write(7, mk(7, 1, 0, 0, 1, 2, 1, 0));
    launch(7, 7, 1, 0, 0, 1, 2, 16'h005A, 16'h00C3);
    wait_done();
    // R11: start while busy is ignored
    cfg_write(2, mk(11, 0, 1, 1, 1, 1, 0, 0));
    fall0 = n_cs_fall;
    launch(2, 11, 0, 1, 1, 1, 1, 16'h0F0F, 16'h0123);
    repeat (10) @(negedge clk);
    start = 1'b1; start_idx = 3'd1; tx_data = 16'hFFFF;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    repeat (20) @(negedge clk);
    check(n_cs_fall == fall0 + 1 && !busy, "R11", "frames started",
          n_cs_fall - fall0, 1);
    // R6: back-to-back frames with opposite polarity; R9 done width
    frame(1, 7, 1, 0, 0, 0, 1, 16'h0081, 16'h007E);
    @(negedge clk);
    check(!done, "R9", "done width", done, 0);
    frame(0, 15, 0, 0, 0, 0, 0, 16'h1234, 16'hFEDC);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule